// File: doc/BRIEF.md
# Timed Event-Table Sequencer

This block runs a small program out of a word-addressed sequence memory and plays out timed events. Each program word is 64 bits. The block keeps sixteen 64-bit general registers. One instruction copies a whole register onto a 64-bit event vector, where every bit gates one piece of hardware. After that, execution stalls for a programmed number of clock cycles. Other instructions load registers from memory, step a register up or down by one, branch on a register being non-zero, set two offset outputs, and mark the end of a repetition period with a one-cycle strobe.

A host fills the memory and then pulses `start_i`. The sequencer fetches from word 0 and runs until it reaches a stop instruction. It then raises `halted_o` and leaves every event bit as the program last set it. The memory port has a single cycle of read latency. The control logic prefetches the next word during stalls, so two event updates are spaced by exactly the programmed delay.

Top module: `pulse_seq_core`

## Requirements
- R1: After reset, and before any start, `pulse_o`, both offset outputs, `tr_strobe_o` and `halted_o` are all 0, and no memory read is issued.
- R2: A cycle with `start_i` high is followed by a cycle that reads memory word 0. The opcode sits in bits [63:58]. Format A puts the register index in [36:32] and a word address in [31:0]. Format B puts the register index in [44:40] and a 40-bit constant in [39:0].
- R3: Opcode 011101 (format B) copies all 64 bits of the selected register onto `pulse_o`. The next instruction executes exactly D cycles later, where D is the constant.
- R4: A delay constant of 0 stalls for the same single cycle as a constant of 1.
- R5: Opcode 000001 subtracts 1 from the selected register and opcode 000010 adds 1. Both wrap modulo 2^64 and take one cycle.
- R6: Opcode 000100 (format A) writes the memory word at the given address into the selected register. It takes two cycles.
- R7: Opcode 010111 always jumps to the address. Opcode 010000 jumps only when the selected register is non-zero and otherwise falls through. Each takes one cycle.
- R8: Opcode 001000 places bits [39:0] on `tx_offset_o`, and opcode 001001 places them on `grad_offset_o`. Each takes one cycle and changes no other output.
- R9: Opcode 000011 (format B) drives `tr_strobe_o` high for one cycle. It then stalls by its constant, following the same rules as R3 and R4.
- R10: Opcode 011001 raises `halted_o`. While halted, the block issues no memory reads and `pulse_o` holds. A new start clears `halted_o` and runs again from word 0.
- R11: Any other opcode behaves as a one-cycle no-operation. Opcode 000000 does the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Restart pulse: program counter to 0, begin fetching |
| mem_rd_o | output | 1 | Sequence memory read enable |
| mem_addr_o | output | ADDR_W | Sequence memory word address |
| mem_rdata_i | input | 64 | Read data, valid one cycle after the read |
| pulse_o | output | 64 | Event vector |
| tx_offset_o | output | 40 | RF pulse offset |
| grad_offset_o | output | 40 | Gradient pulse offset |
| tr_strobe_o | output | 1 | One-cycle end-of-period strobe |
| halted_o | output | 1 | Program reached the stop instruction |

## Verification
The hardest property to reach from the ports is the exact spacing of event updates. It has to hold when a one-cycle stall is followed immediately by another fetch, and when untimed instructions or register loads sit between two timed ones. The bench builds programs of back-to-back pulse instructions with random registers and delays of 0, 1, small and large values. It logs the cycle of every change on `pulse_o` and compares each gap with the programmed delay. Directed programs then place decrement, increment, offset, unknown-opcode and branch words between timed instructions, and they check gaps that include each of those instructions' fixed costs.

// File: rtl/pseq_pkg.sv
// pseq_pkg: shared encodings and types for the timed event-table sequencer.
// Assumes 64-bit instruction words with a 6-bit opcode at the top.
package pseq_pkg;
    localparam int WORD_W  = 64;
    localparam int OPC_W   = 6;
    localparam int CONST_W = 40;
    localparam int FADDR_W = 32;
    localparam int NREG    = 16;
    localparam int IDX_W   = $clog2(NREG);

    localparam int OPC_LSB  = WORD_W - OPC_W;
    localparam int FA_IDX_L = FADDR_W;
    localparam int FB_IDX_L = CONST_W;

    typedef enum logic [OPC_W-1:0] {
        OPC_NOP  = 6'b000000,
        OPC_DEC  = 6'b000001,
        OPC_INC  = 6'b000010,
        OPC_LITR = 6'b000011,
        OPC_LD   = 6'b000100,
        OPC_TXO  = 6'b001000,
        OPC_GRO  = 6'b001001,
        OPC_JNZ  = 6'b010000,
        OPC_JMP  = 6'b010111,
        OPC_HALT = 6'b011001,
        OPC_PR   = 6'b011101
    } opcode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC,
        ST_WAIT,
        ST_LOAD,
        ST_HALT
    } state_e;

    typedef struct packed {
        logic                is_dec;
        logic                is_inc;
        logic                is_ld;
        logic                is_jnz;
        logic                is_jmp;
        logic                is_pr;
        logic                is_litr;
        logic                is_txo;
        logic                is_gro;
        logic                is_halt;
        logic                long_wait;
        logic [IDX_W-1:0]    rx;
        logic [FADDR_W-1:0]  addr;
        logic [CONST_W-1:0]  konst;
    } instr_t;
endpackage

// File: rtl/pseq_decode.sv
// pseq_decode: splits a fetched word into one-hot operation flags and fields.
// Assumes the word is only meaningful in the execute state; unknown opcodes
// leave every flag low, so the controller treats them as a no-operation.
module pseq_decode
    import pseq_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    output instr_t            ins_o
);
    logic [OPC_W-1:0] opc;
    logic             fmt_b;

    assign opc = word_i[WORD_W-1:OPC_LSB];

    // Flag the decoded operation; defaults leave an unknown code inert.
    always_comb begin
        ins_o = '0;
        unique case (opc)
            OPC_DEC:  ins_o.is_dec  = 1'b1;
            OPC_INC:  ins_o.is_inc  = 1'b1;
            OPC_LD:   ins_o.is_ld   = 1'b1;
            OPC_JNZ:  ins_o.is_jnz  = 1'b1;
            OPC_JMP:  ins_o.is_jmp  = 1'b1;
            OPC_PR:   ins_o.is_pr   = 1'b1;
            OPC_LITR: ins_o.is_litr = 1'b1;
            OPC_TXO:  ins_o.is_txo  = 1'b1;
            OPC_GRO:  ins_o.is_gro  = 1'b1;
            OPC_HALT: ins_o.is_halt = 1'b1;
            default:  ;
        endcase
        ins_o.konst     = word_i[CONST_W-1:0];
        ins_o.addr      = word_i[FADDR_W-1:0];
        ins_o.long_wait = (word_i[CONST_W-1:0] > CONST_W'(1));
        ins_o.rx        = fmt_b ? word_i[FB_IDX_L +: IDX_W]
                                : word_i[FA_IDX_L +: IDX_W];
    end

    // Timed and offset operations carry their register index in the format-B field.
    assign fmt_b = (opc == OPC_PR) || (opc == OPC_LITR) ||
                   (opc == OPC_TXO) || (opc == OPC_GRO);
endmodule

// File: rtl/pseq_regfile.sv
// pseq_regfile: general register bank with one combinational read port and
// one synchronous write port. Assumes a single write per cycle.
module pseq_regfile #(
    parameter int N     = 16,
    parameter int W     = 64,
    localparam int IW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] rd_idx_i,
    output logic [W-1:0]  rd_data_o,
    input  logic          wr_en_i,
    input  logic [IW-1:0] wr_idx_i,
    input  logic [W-1:0]  wr_data_i
);
    logic [W-1:0] regs_q [N];

    // Each register clears on reset and updates when addressed.
    for (genvar g = 0; g < N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en_i && (wr_idx_i == IW'(g)))
                regs_q[g] <= wr_data_i;
        end
    end

    assign rd_data_o = regs_q[rd_idx_i];
endmodule

// File: rtl/pseq_delay.sv
// pseq_delay: down-counter for instruction stalls. Loaded with (delay - 1)
// when the delay exceeds one; last_o marks the cycle that issues the next fetch.
module pseq_delay #(
    parameter int CW = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          tick_i,
    output logic          last_o
);
    logic [CW-1:0] cnt_q;

    // Load a fresh stall length or count down one step per waiting cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load_i)
            cnt_q <= load_val_i;
        else if (tick_i && (cnt_q != '0))
            cnt_q <= cnt_q - CW'(1);
    end

    assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/pseq_ctrl.sv
// pseq_ctrl: fetch/execute state machine. Executes the word returned by
// memory in the execute state and issues the next read in the same cycle,
// so untimed operations cost one cycle and stalls are exact.
// Assumes one cycle of memory read latency and ADDR_W <= 32.
module pseq_ctrl
    import pseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  instr_t            ins_i,
    input  logic [WORD_W-1:0] rf_rdata_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              tmr_last_i,
    output logic              mem_rd_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              rf_we_o,
    output logic [IDX_W-1:0]  rf_widx_o,
    output logic [WORD_W-1:0] rf_wdata_o,
    output logic              tmr_load_o,
    output logic [CONST_W-1:0] tmr_val_o,
    output logic              tmr_tick_o,
    output logic              exec_pr_o,
    output logic              exec_txo_o,
    output logic              exec_gro_o,
    output logic              exec_litr_o,
    output logic              in_wait_o,
    output logic              halted_o
);
    state_e            state_q, state_d;
    logic [ADDR_W-1:0] pc_q, pc_d;
    logic [IDX_W-1:0]  ld_idx_q;
    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] target;
    logic              in_exec;
    logic              branch;

    assign seq_pc  = pc_q + ADDR_W'(1);
    assign target  = ins_i.addr[ADDR_W-1:0];
    assign in_exec = (state_q == ST_EXEC);
    assign branch  = ins_i.is_jmp || (ins_i.is_jnz && (rf_rdata_i != '0));

    // Next state, next program counter and memory read request.
    always_comb begin
        state_d    = state_q;
        pc_d       = pc_q;
        mem_rd_o   = 1'b0;
        mem_addr_o = pc_q;
        tmr_load_o = 1'b0;
        tmr_tick_o = 1'b0;
        unique case (state_q)
            ST_FETCH: begin
                mem_rd_o = 1'b1;
                state_d  = ST_EXEC;
            end
            ST_EXEC: begin
                if (ins_i.is_halt) begin
                    state_d = ST_HALT;
                end else if (ins_i.is_ld) begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = target;
                    state_d    = ST_LOAD;
                end else if (branch) begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = target;
                    pc_d       = target;
                end else if ((ins_i.is_pr || ins_i.is_litr) && ins_i.long_wait) begin
                    tmr_load_o = 1'b1;
                    pc_d       = seq_pc;
                    state_d    = ST_WAIT;
                end else begin
                    mem_rd_o   = 1'b1;
                    mem_addr_o = seq_pc;
                    pc_d       = seq_pc;
                end
            end
            ST_WAIT: begin
                tmr_tick_o = 1'b1;
                if (tmr_last_i) begin
                    mem_rd_o = 1'b1;
                    state_d  = ST_EXEC;
                end
            end
            ST_LOAD: begin
                mem_rd_o   = 1'b1;
                mem_addr_o = seq_pc;
                pc_d       = seq_pc;
                state_d    = ST_EXEC;
            end
            default: ;
        endcase
        if (start_i) begin
            state_d = ST_FETCH;
            pc_d    = '0;
        end
    end

    // Register write port: load data in the load state, else step by one.
    always_comb begin
        rf_we_o    = 1'b0;
        rf_widx_o  = ins_i.rx;
        rf_wdata_o = ins_i.is_inc ? rf_rdata_i + WORD_W'(1)
                                  : rf_rdata_i - WORD_W'(1);
        if (state_q == ST_LOAD) begin
            rf_we_o    = 1'b1;
            rf_widx_o  = ld_idx_q;
            rf_wdata_o = mem_rdata_i;
        end else if (in_exec && (ins_i.is_inc || ins_i.is_dec)) begin
            rf_we_o = 1'b1;
        end
    end

    assign tmr_val_o   = ins_i.konst - CONST_W'(1);
    assign exec_pr_o   = in_exec && ins_i.is_pr;
    assign exec_txo_o  = in_exec && ins_i.is_txo;
    assign exec_gro_o  = in_exec && ins_i.is_gro;
    assign exec_litr_o = in_exec && ins_i.is_litr;
    assign in_wait_o   = (state_q == ST_WAIT);
    assign halted_o    = (state_q == ST_HALT);

    // Sequencing state, program counter and pending load destination.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            pc_q     <= '0;
            ld_idx_q <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            if (in_exec && ins_i.is_ld)
                ld_idx_q <= ins_i.rx;
        end
    end
endmodule

// File: rtl/pulse_seq_core.sv
// pulse_seq_core: top of the timed event-table sequencer. Ties decode,
// register bank, stall counter and controller together and registers the
// event vector, offsets and period strobe. Assumes a synchronous memory
// with one cycle of read latency.
module pulse_seq_core
    import pseq_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    output logic               mem_rd_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    input  logic [WORD_W-1:0]  mem_rdata_i,
    output logic [WORD_W-1:0]  pulse_o,
    output logic [CONST_W-1:0] tx_offset_o,
    output logic [CONST_W-1:0] grad_offset_o,
    output logic               tr_strobe_o,
    output logic               halted_o
);
    instr_t             ins;
    logic [WORD_W-1:0]  rf_rdata;
    logic               rf_we;
    logic [IDX_W-1:0]   rf_widx;
    logic [WORD_W-1:0]  rf_wdata;
    logic               tmr_load;
    logic [CONST_W-1:0] tmr_val;
    logic               tmr_tick;
    logic               tmr_last;
    logic               exec_pr;
    logic               exec_txo;
    logic               exec_gro;
    logic               exec_litr;
    logic               in_wait;

    pseq_decode u_dec (
        .word_i (mem_rdata_i),
        .ins_o  (ins)
    );

    pseq_regfile #(.N(NREG), .W(WORD_W)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx_i  (ins.rx),
        .rd_data_o (rf_rdata),
        .wr_en_i   (rf_we),
        .wr_idx_i  (rf_widx),
        .wr_data_i (rf_wdata)
    );

    pseq_delay #(.CW(CONST_W)) u_dly (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .tick_i     (tmr_tick),
        .last_o     (tmr_last)
    );

    pseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .ins_i       (ins),
        .rf_rdata_i  (rf_rdata),
        .mem_rdata_i (mem_rdata_i),
        .tmr_last_i  (tmr_last),
        .mem_rd_o    (mem_rd_o),
        .mem_addr_o  (mem_addr_o),
        .rf_we_o     (rf_we),
        .rf_widx_o   (rf_widx),
        .rf_wdata_o  (rf_wdata),
        .tmr_load_o  (tmr_load),
        .tmr_val_o   (tmr_val),
        .tmr_tick_o  (tmr_tick),
        .exec_pr_o   (exec_pr),
        .exec_txo_o  (exec_txo),
        .exec_gro_o  (exec_gro),
        .exec_litr_o (exec_litr),
        .in_wait_o   (in_wait),
        .halted_o    (halted_o)
    );

    // Event vector, offsets and strobe update only when their operation executes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_o       <= '0;
            tx_offset_o   <= '0;
            grad_offset_o <= '0;
            tr_strobe_o   <= 1'b0;
        end else begin
            tr_strobe_o <= exec_litr;
            if (exec_pr)
                pulse_o <= rf_rdata;
            if (exec_txo)
                tx_offset_o <= ins.konst;
            if (exec_gro)
                grad_offset_o <= ins.konst;
        end
    end
endmodule

// File: rtl/pseq_sva.sv
// pseq_sva: protocol checks for pulse_seq_core, bound to every instance.
module pseq_sva #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              mem_rd_o,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [63:0]       pulse_o,
    input logic [39:0]       tx_offset_o,
    input logic [39:0]       grad_offset_o,
    input logic              tr_strobe_o,
    input logic              halted_o,
    input logic              exec_pr,
    input logic              exec_txo,
    input logic              exec_gro,
    input logic              exec_litr,
    input logic              in_wait,
    input logic              tmr_last
);
    assert_start_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (mem_rd_o && (mem_addr_o == '0)));

    assert_pulse_from_pr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pulse_o) |-> $past(exec_pr));

    assert_wait_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && !tmr_last && !start_i) |=> in_wait);

    assert_wait_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && tmr_last) |=> !in_wait);

    assert_txo_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_offset_o) |-> $past(exec_txo));

    assert_gro_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grad_offset_o) |-> $past(exec_gro));

    assert_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tr_strobe_o |-> $past(exec_litr));

    assert_halt_no_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        halted_o |-> !mem_rd_o);

    assert_halt_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_o && !start_i) |=> (halted_o && $stable(pulse_o)));
endmodule

bind pulse_seq_core pseq_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .mem_rd_o      (mem_rd_o),
    .mem_addr_o    (mem_addr_o),
    .pulse_o       (pulse_o),
    .tx_offset_o   (tx_offset_o),
    .grad_offset_o (grad_offset_o),
    .tr_strobe_o   (tr_strobe_o),
    .halted_o      (halted_o),
    .exec_pr       (exec_pr),
    .exec_txo      (exec_txo),
    .exec_gro      (exec_gro),
    .exec_litr     (exec_litr),
    .in_wait       (in_wait),
    .tmr_last      (tmr_last)
);

// File: tb/pulse_seq_core_tb_top.sv
`timescale 1ns/1ps
module pulse_seq_core_tb_top;
    localparam int AW = 32;
    localparam logic [5:0] O_NOP = 6'b000000, O_DEC = 6'b000001, O_INC = 6'b000010,
                           O_LITR = 6'b000011, O_LD = 6'b000100, O_TXO = 6'b001000,
                           O_GRO = 6'b001001, O_JNZ = 6'b010000, O_JMP = 6'b010111,
                           O_HALT = 6'b011001, O_PR = 6'b011101;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic          mem_rd_o;
    logic [AW-1:0] mem_addr_o;
    logic [63:0]   mem_rdata_i = '0;
    logic [63:0]   pulse_o;
    logic [39:0]   tx_offset_o, grad_offset_o;
    logic          tr_strobe_o, halted_o;

    always #4 clk = ~clk;

    pulse_seq_core #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i),
        .pulse_o(pulse_o), .tx_offset_o(tx_offset_o), .grad_offset_o(grad_offset_o),
        .tr_strobe_o(tr_strobe_o), .halted_o(halted_o)
    );

    logic [63:0] mem [256];
    always @(posedge clk) if (mem_rd_o) mem_rdata_i <= mem[mem_addr_o[7:0]];

    int cyc = 0;
    int n_chk = 0, n_bad = 0;
    int ev_n = 0, st_n = 0, halt_rd = 0;
    int ev_t [64];
    logic [63:0] ev_v [64];
    int st_t [64];
    logic [63:0] prev_pulse = '0;

    always @(posedge clk) cyc <= cyc + 1;

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) if (cyc > 150000) begin
        n_bad++;
        $display("FAIL R10 watchdog: cycles=%0d expected < 150000", cyc);
        $display("  test done: total=%0d bad=%0d", n_chk + 1, n_bad);
        $finish;
    end

    // Event log sampled away from the active edge.
    always @(negedge clk) if (rst_n) begin
        if (pulse_o !== prev_pulse) begin
            if (ev_n < 64) begin ev_t[ev_n] = cyc; ev_v[ev_n] = pulse_o; end
            ev_n++;
            prev_pulse = pulse_o;
        end
        if (tr_strobe_o) begin
            if (st_n < 64) st_t[st_n] = cyc;
            st_n++;
        end
        if (halted_o && mem_rd_o) halt_rd++;
    end

    function automatic logic [63:0] fa(input logic [5:0] op, input int idx, input int addr);
        return {op, 21'b0, 5'(idx), 32'(addr)};
    endfunction
    function automatic logic [63:0] fb(input logic [5:0] op, input int idx, input logic [39:0] k);
        return {op, 13'b0, 5'(idx), k};
    endfunction
    function automatic int eff_delay(input int d);
        return (d < 1) ? 1 : d;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic chk_gap(input string req, input int i, input int exp);
        chk(req, $sformatf("gap before event %0d", i), 64'(ev_t[i] - ev_t[i-1]), 64'(exp));
    endtask

    task automatic fill_halt();
        for (int i = 0; i < 256; i++) mem[i] = fa(O_HALT, 0, 0);
    endtask

    // Start the program and wait for it to stop; checks restart and halt behaviour.
    task automatic run_prog();
        logic [63:0] held;
        int w;
        @(negedge clk);
        ev_n = 0; st_n = 0; halt_rd = 0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2", "first read enable", 64'(mem_rd_o), 64'd1);
        chk("R2", "first read address", 64'(mem_addr_o), 64'd0);
        chk("R10", "halted cleared by start", 64'(halted_o), 64'd0);
        w = 0;
        while (!halted_o && w < 20000) begin @(negedge clk); w++; end
        chk("R10", "halted reached", 64'(halted_o), 64'd1);
        held = pulse_o;
        repeat (6) @(negedge clk);
        chk("R10", "pulse held while halted", pulse_o, held);
        chk("R10", "reads while halted", 64'(halt_rd), 64'd0);
    endtask

    localparam logic [63:0] V1 = 64'hA5A5_0000_0000_0001;
    localparam logic [63:0] V2 = 64'hA5A5_0000_0000_0002;
    localparam logic [63:0] V3 = 64'h0000_1111_2222_3333;
    localparam logic [63:0] V4 = 64'h8000_0000_0000_0000;
    localparam logic [63:0] V6 = 64'h0F0F_F0F0_1234_5678;

    initial begin
        logic [63:0] vals [9];
        int exp_d [16];
        logic [63:0] exp_v [16];
        void'($urandom(32'd20240611));

        fill_halt();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: quiet state after reset
        chk("R1", "pulse after reset", pulse_o, 64'd0);
        chk("R1", "tx offset after reset", 64'(tx_offset_o), 64'd0);
        chk("R1", "grad offset after reset", 64'(grad_offset_o), 64'd0);
        chk("R1", "strobe after reset", 64'(tr_strobe_o), 64'd0);
        chk("R1", "halted after reset", 64'(halted_o), 64'd0);
        chk("R1", "read after reset", 64'(mem_rd_o), 64'd0);

        // Directed: loads, delays 0/1, unknown opcode, step ops, offsets
        fill_halt();
        mem[100] = V1; mem[101] = V2;
        mem[0]  = fa(O_LD, 1, 100);
        mem[1]  = fa(O_LD, 2, 101);
        mem[2]  = fb(O_PR, 1, 40'd0);
        mem[3]  = fb(O_PR, 2, 40'd1);
        mem[4]  = fb(O_PR, 1, 40'd7);
        mem[5]  = {6'b111111, 58'h2AB_CDEF_0123_4567};
        mem[6]  = fb(O_PR, 2, 40'd3);
        mem[7]  = fa(O_DEC, 9, 0);
        mem[8]  = fb(O_PR, 9, 40'd2);
        mem[9]  = fa(O_INC, 9, 0);
        mem[10] = fa(O_INC, 9, 0);
        mem[11] = fb(O_PR, 9, 40'd1);
        mem[12] = fb(O_TXO, 0, 40'h12_3456_789A);
        mem[13] = fb(O_GRO, 0, 40'hAB_CDEF_0123);
        mem[14] = fb(O_PR, 1, 40'd1);
        mem[15] = fa(O_HALT, 0, 0);
        run_prog();
        chk("R3", "directed event count", 64'(ev_n), 64'd7);
        chk("R6", "loaded R1 value", ev_v[0], V1);
        chk("R6", "loaded R2 value", ev_v[1], V2);
        chk("R4", "zero delay spacing", 64'(ev_t[1] - ev_t[0]), 64'd1);
        chk_gap("R4", 2, 1);
        chk_gap("R11", 3, 8);
        chk("R5", "decrement wraps", ev_v[4], 64'hFFFF_FFFF_FFFF_FFFF);
        chk_gap("R5", 4, 4);
        chk("R5", "two increments", ev_v[5], 64'd1);
        chk_gap("R5", 5, 4);
        chk_gap("R8", 6, 3);
        chk("R3", "last event value", ev_v[6], V1);
        chk("R8", "tx offset", 64'(tx_offset_o), 64'h12_3456_789A);
        chk("R8", "grad offset", 64'(grad_offset_o), 64'hAB_CDEF_0123);
        chk("R9", "no strobe without period op", 64'(st_n), 64'd0);

        // Directed: counted loop with conditional and unconditional jumps
        fill_halt();
        mem[100] = 64'd3; mem[101] = V3; mem[102] = V4;
        mem[0] = fa(O_LD, 10, 100);
        mem[1] = fa(O_LD, 3, 101);
        mem[2] = fa(O_LD, 4, 102);
        mem[3] = fb(O_PR, 3, 40'd5);
        mem[4] = fb(O_PR, 4, 40'd5);
        mem[5] = fa(O_DEC, 10, 0);
        mem[6] = fa(O_JNZ, 10, 3);
        mem[7] = fa(O_JMP, 0, 9);
        mem[8] = fb(O_PR, 5, 40'd1);
        mem[9] = fa(O_HALT, 0, 0);
        run_prog();
        chk("R7", "loop event count", 64'(ev_n), 64'd6);
        for (int i = 0; i < 6 && i < ev_n; i++)
            chk("R7", $sformatf("loop value %0d", i), ev_v[i], (i % 2 == 0) ? V3 : V4);
        for (int i = 1; i < 6 && i < ev_n; i++)
            chk_gap("R7", i, (i % 2 == 1) ? 5 : 7);
        chk("R7", "jump skipped word", pulse_o, V4);

        // Directed: period strobe with long and zero delays
        fill_halt();
        mem[100] = V6;
        mem[0] = fa(O_LD, 6, 100);
        mem[1] = fb(O_PR, 6, 40'd4);
        mem[2] = fb(O_LITR, 0, 40'd6);
        mem[3] = fb(O_LITR, 0, 40'd0);
        mem[4] = fb(O_PR, 1, 40'd1);
        mem[5] = fa(O_HALT, 0, 0);
        run_prog();
        chk("R9", "strobe count", 64'(st_n), 64'd2);
        chk("R9", "event count", 64'(ev_n), 64'd2);
        chk("R9", "strobe after pulse", 64'(st_t[0] - ev_t[0]), 64'd4);
        chk("R9", "strobe spacing", 64'(st_t[1] - st_t[0]), 64'd6);
        chk("R9", "pulse after zero-delay strobe", 64'(ev_t[1] - st_t[1]), 64'd1);

        // Random back-to-back timed events
        for (int it = 0; it < 30; it++) begin
            int pc, prev_r;
            fill_halt();
            for (int r = 1; r <= 8; r++) begin
                vals[r] = {$urandom, $urandom} | 64'h1;
                mem[200 + r] = vals[r];
                mem[r - 1] = fa(O_LD, r, 200 + r);
            end
            pc = 8; prev_r = 0;
            for (int j = 0; j < 10; j++) begin
                int r, d;
                r = 1 + int'($urandom % 8);
                if (r == prev_r) r = (r % 8) + 1;
                d = int'($urandom % 16);
                if ($urandom % 5 == 0) d = 16 + int'($urandom % 200);
                mem[pc] = fb(O_PR, r, 40'(d));
                exp_v[j] = vals[r];
                exp_d[j] = eff_delay(d);
                prev_r = r; pc++;
            end
            run_prog();
            chk("R3", $sformatf("random run %0d event count", it), 64'(ev_n), 64'd10);
            for (int j = 0; j < 10 && j < ev_n; j++) begin
                chk("R3", $sformatf("random run %0d value %0d", it, j), ev_v[j], exp_v[j]);
                if (j > 0) chk_gap("R3", j, exp_d[j-1]);
            end
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule